// File: doc/BRIEF.md
# Two-Stage Pipelined 4-to-16 One-Hot Decoder

The block turns a 4-bit binary code into a 16-bit one-hot word over two registered pipeline stages, so no single stage has to look at all four bits at once. The first stage holds one registered 2-to-4 decoder that looks only at the upper pair of code bits. Its registered one-hot result enables exactly one of four registered 2-to-4 decoders in the second stage. The enabled decoder turns the lower pair of code bits, delayed by one register, into its group of four outputs. The three disabled decoders register zeros.

A valid flag travels with the data through both stages. The block accepts a new code on every clock cycle, and the decoded word appears exactly two clock edges after its code was sampled. An asynchronous active-low reset clears every pipeline register.

Top module: `pipe_dec16`

## Requirements
- R1: While reset is asserted, and after it is released with no valid input yet sampled, `dec_out` is 16'h0000 and `dec_valid` is 0.
- R2: `dec_valid` is 1 exactly two rising clock edges after an edge that sampled `code_valid`=1, and 0 two edges after an edge that sampled `code_valid`=0.
- R3: When `dec_valid` is 1, `dec_out` has exactly one bit set, and that bit's index equals the binary value of the code sampled two edges earlier (code 0 sets bit 0, code 15 sets bit 15).
- R4: When `dec_valid` is 0, `dec_out` is all zeros.
- R5: Code bits [3:2] with value k select output group k (bits 4k to 4k+3). Code bits [1:0] select the bit within that group. The other twelve output bits are zero.
- R6: Codes presented on consecutive cycles come out on consecutive cycles in the same order, with no idle cycle between them.
- R7: Asserting the reset clears `dec_out` and `dec_valid` at once, without waiting for a clock edge, and discards any codes still in the pipeline.
- R8: Values on `code_in` while `code_valid` is 0 have no effect on `dec_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_in | input | 4 | Binary code to decode |
| code_valid | input | 1 | Marks `code_in` as valid in this cycle |
| dec_out | output | 16 | Registered one-hot result |
| dec_valid | output | 1 | Marks `dec_out` as holding a decoded code |

## Verification
The bench walks every one of the 16 codes in isolation. A swapped or misrouted group, or a lower-bit select taken from the wrong cycle, therefore lights the wrong bit or two bits at once. A run of back-to-back codes in a scrambled order would expose a missing delay on the lower bits, since each word would then combine the upper pair of one code with the lower pair of the next. It would also expose a bubble or extra latency, which shows up as a skipped or duplicated code.

Junk on `code_in` with the valid flag low must leave the output at zero. A decoder left enabled when idle would light stray bits. A reset asserted mid-stream is checked before the next clock edge, which catches a reset wired as synchronous.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int CODE_W = 4;
  localparam int SEL_W  = CODE_W / 2;
  localparam int GRP_W  = 1 << SEL_W;
  localparam int N_GRP  = 1 << SEL_W;
  localparam int OUT_W  = 1 << CODE_W;

  // One-hot image of a select value: bit s is set.
  function automatic logic [GRP_W-1:0] sel_onehot(input logic [SEL_W-1:0] s);
    logic [GRP_W-1:0] r;
    r    = '0;
    r[s] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/stage_reg.sv
module stage_reg #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/dec2_unit.sv
module dec2_unit
  import dec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic [GRP_W-1:0] q
);
  logic [GRP_W-1:0] nxt;

  always_comb nxt = en ? sel_onehot(sel) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  AST_UNIT_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (q == '0)) else $error("disabled unit not cleared"); // R4
  AST_UNIT_ON_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $onehot(q)) else $error("enabled unit not one-hot"); // R3
endmodule

// File: rtl/pipe_dec16.sv
module pipe_dec16
  import dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_in,
  input  logic              code_valid,
  output logic [OUT_W-1:0]  dec_out,
  output logic              dec_valid
);
  // Named internal events for the checks below.
  logic [N_GRP-1:0] grp_sel;   // stage-1 registered group enable
  logic [SEL_W-1:0] lo_d;      // lower code bits, aligned with grp_sel
  logic             v1;        // stage-1 valid

  dec2_unit u_hi (
    .clk(clk), .rst_n(rst_n), .en(code_valid),
    .sel(code_in[CODE_W-1 -: SEL_W]), .q(grp_sel)
  );

  stage_reg #(.W(SEL_W + 1)) u_lo_dly (
    .clk(clk), .rst_n(rst_n),
    .d({code_valid, code_in[SEL_W-1:0]}),
    .q({v1, lo_d})
  );

  stage_reg #(.W(1)) u_v2 (
    .clk(clk), .rst_n(rst_n), .d(v1), .q(dec_valid)
  );

  for (genvar k = 0; k < N_GRP; k++) begin : g_grp
    dec2_unit u_lo (
      .clk(clk), .rst_n(rst_n), .en(grp_sel[k]),
      .sel(lo_d), .q(dec_out[k*GRP_W +: GRP_W])
    );
    AST_GROUP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !grp_sel[k] |=> (dec_out[k*GRP_W +: GRP_W] == '0))
      else $error("unselected group active"); // R5
  end

  AST_STAGE1_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid |=> v1) else $error("stage-1 valid lost"); // R2
  AST_STAGE2_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    v1 |=> dec_valid) else $error("output valid lost"); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !v1 |=> !dec_valid) else $error("spurious output valid"); // R2
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    v1 |-> $onehot(grp_sel)) else $error("group select not one-hot"); // R5
  AST_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !v1 |-> (grp_sel == '0)) else $error("group select while idle"); // R8
  AST_OUT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $onehot(dec_out)) else $error("output not one-hot"); // R3
  AST_OUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (dec_out == '0)) else $error("output not zero when idle"); // R4
endmodule

// File: tb/pipe_dec16_test.sv
`timescale 1ns/1ps
module pipe_dec16_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  code_in = '0;
  logic        code_valid = 1'b0;
  logic [15:0] dec_out;
  logic        dec_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  pipe_dec16 uut (
    .clk(clk), .rst_n(rst_n), .code_in(code_in), .code_valid(code_valid),
    .dec_out(dec_out), .dec_valid(dec_valid)
  );

  always #10 clk = ~clk;  // 50 MHz

  function automatic logic [15:0] expect_word(input logic [3:0] c);
    logic [15:0] w;
    w = 16'h0;
    w[{c[3:2], c[1:0]}] = 1'b1;
    return w;
  endfunction

  task automatic check(input string req, input logic [16:0] got, input logic [16:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got valid=%0b out=%04h, expected valid=%0b out=%04h",
               req, got[16], got[15:0], exp[16], exp[15:0]);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    code_valid = 1'b1;
    code_in = 4'hA;
    repeat (2) @(negedge clk);
    check("R1 during reset", {dec_valid, dec_out}, 17'h0);
    code_valid = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after reset", {dec_valid, dec_out}, 17'h0);
  endtask

  task automatic t_each_code();
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      code_in = c[3:0];
      code_valid = 1'b1;
      @(negedge clk);
      code_valid = 1'b0;
      code_in = ~c[3:0];
      @(negedge clk);
      check("R3 R5 single code", {dec_valid, dec_out}, {1'b1, expect_word(c[3:0])});
      @(negedge clk);
      check("R2 R4 valid drops", {dec_valid, dec_out}, 17'h0);
    end
  endtask

  task automatic t_back_to_back();
    logic [3:0] seq [16];
    for (int i = 0; i < 16; i++) seq[i] = 4'((i * 7 + 3) % 16);
    for (int i = 0; i < 19; i++) begin
      @(negedge clk);
      if (i >= 2 && i < 18)
        check("R6 back-to-back", {dec_valid, dec_out}, {1'b1, expect_word(seq[i-2])});
      if (i == 18)
        check("R2 stream end", {dec_valid, dec_out}, 17'h0);
      if (i < 16) begin
        code_in = seq[i];
        code_valid = 1'b1;
      end else begin
        code_valid = 1'b0;
      end
    end
  endtask

  task automatic t_ignore_invalid();
    @(negedge clk);
    code_valid = 1'b0;
    for (int i = 0; i < 6; i++) begin
      code_in = 4'(i * 5 + 1);
      @(negedge clk);
      if (i >= 2) check("R8 invalid ignored", {dec_valid, dec_out}, 17'h0);
    end
  endtask

  task automatic t_async_reset();
    @(negedge clk);
    code_in = 4'h9;
    code_valid = 1'b1;
    @(negedge clk);
    code_in = 4'h6;
    @(negedge clk);
    code_valid = 1'b0;
    check("R3 before reset", {dec_valid, dec_out}, {1'b1, expect_word(4'h9)});
    #4 rst_n = 1'b0;
    #1 check("R7 async clear", {dec_valid, dec_out}, 17'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 pipeline flushed", {dec_valid, dec_out}, 17'h0);
    @(negedge clk);
    check("R7 no late output", {dec_valid, dec_out}, 17'h0);
  endtask

  initial begin
    t_reset();
    t_each_code();
    t_back_to_back();
    t_ignore_invalid();
    t_async_reset();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule